// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one fixed-size page between a byte-wide storage card stream and word-addressed host memory. Every transfer passes through a private page buffer and is split into two phases that software arms one at a time. The card phase moves bytes between the card stream and the buffer. The host phase moves 32-bit words between the buffer and host memory.

For a read (card to host), software arms the card phase first and the host phase second. For a write (host to card), the order is reversed. Software loads the host base address, arms a phase by writing the settings register, and waits for that phase's done status. It then arms the other phase. The page is complete only when the second phase reports done. Status bits are cleared by writing ones to them, and a single interrupt line is driven from the enabled status bits.

Top module: `page_dma_seq`

## Requirements
- R1: One phase moves exactly one page: 512 card bytes on the card side, or 128 host words on the host side. Host word i uses address base + 4*i. Card bytes are packed little-endian, so byte 4*i lands in bits 7:0 of word i.
- R2: Read transfer (settings bit 0 = 1): the card phase fills the buffer from the card input stream and makes no host request. The following host phase then writes the 128 words to host memory with the write flag set.
- R3: Write transfer (settings bit 0 = 0): the host phase reads 128 words into the buffer and drives no card output. The following card phase then sends the 512 bytes on the card output stream.
- R4: Register offsets are: 0 settings, 1 host address, 2 interrupt enable, 3 status. Settings bit 0 is the direction, bit 1 selects the card phase and bit 2 selects the host phase. Writing the settings with exactly one phase bit set arms that phase. Its phase bit reads back as 1 while the phase runs and as 0 once it ends.
- R5: An arm request with both phase bits set, or with the phase that does not match the direction and step, sets status bit 2 (error) and starts no transfer. The step is first phase versus second phase.
- R6: An arm request while a phase is running sets the error bit, stops the running phase and starts nothing new.
- R7: A host error (mem_err together with mem_ack) sets the error bit, ends the host phase at once, clears both phase bits and returns the sequence to its first step.
- R8: Status bit 0 (card phase done) or bit 1 (host phase done) reads as 1 in the cycle right after the clock edge of the phase's last byte or word handshake, and reads as 0 before it.
- R9: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: Interrupt-enable bits 0, 1 and 2 match the status bits. irq is high exactly when some status bit and its enable are both 1.
- R11: The host address register reads back the value last written.
- R12: A settings write with no phase bit stops any running phase without raising an error and returns the sequence to its first step.
- R13: After reset all four registers read zero, and irq, mem_req, card_in_ready and card_out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Host word request, held until mem_ack |
| mem_we | output | 1 | Host request is a write |
| mem_addr | output | ADDR_W | Host byte address of the current word |
| mem_wdata | output | 32 | Host write data |
| mem_ack | input | 1 | Host accepts the current word |
| mem_err | input | 1 | Host reports an error for the acknowledged word |
| mem_rdata | input | 32 | Host read data, valid with mem_ack |
| card_in_valid | input | 1 | Card byte available |
| card_in_data | input | 8 | Card byte into the block |
| card_in_ready | output | 1 | Block accepts a card byte |
| card_out_valid | output | 1 | Byte toward the card available |
| card_out_data | output | 8 | Byte toward the card |
| card_out_ready | input | 1 | Card accepts the byte |

## Verification
A register write takes effect at the clock edge where reg_we is high. The bench therefore reads its effect (error bit, phase bits, irq, request lines) at the falling edge that follows. Phase-done bits are due in the cycle after the last handshake edge. The bench counts handshakes at the same edges as the design. At each falling edge it checks that the done bit is still low while the count is below a page, and high at the first falling edge where the count reaches a full page. A host error word is due to stop the host phase at its own acknowledge edge, so the bench expects exactly six counted handshakes and no request at the next falling edge.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_ADDR = 2'd1,
        REG_IEN  = 2'd2,
        REG_STS  = 2'd3
    } reg_sel_e;

    // settings register bit positions
    localparam int CFG_DIR = 0;
    localparam int CFG_INT = 1;
    localparam int CFG_MEM = 2;

    // status / interrupt-enable bit positions
    localparam int EV_INT  = 0;
    localparam int EV_MEM  = 1;
    localparam int EV_ERR  = 2;
    localparam int EV_N    = 3;

endpackage

// File: rtl/page_dma_buf.sv
module page_dma_buf #(
    parameter int WORDS = 128,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [31:0]      rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [31:0]      rdata_b
);

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata_a = mem_q[ridx_a];
    assign rdata_b = mem_q[ridx_b];

endmodule

// File: rtl/page_dma_card_eng.sv
module page_dma_card_eng #(
    parameter int PAGE_BYTES = 512,
    parameter int BCNT_W     = $clog2(PAGE_BYTES),
    parameter int IDX_W      = BCNT_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             to_buf,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic [IDX_W-1:0] buf_ridx,
    input  logic [31:0]      buf_rdata,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [31:0]      buf_wdata,
    output logic             active,
    output logic             done
);

    typedef struct packed {
        logic              active;
        logic              to_buf;
        logic [BCNT_W-1:0] cnt;
        logic [23:0]       acc;
    } card_st_t;

    card_st_t q, d;
    logic hs;
    logic last;

    always_comb begin
        d    = q;
        hs   = q.active && (q.to_buf ? in_valid : out_ready);
        last = (q.cnt == BCNT_W'(PAGE_BYTES - 1));
        done = hs && last;

        in_ready  = q.active && q.to_buf;
        out_valid = q.active && !q.to_buf;
        out_data  = buf_rdata[{q.cnt[1:0], 3'b000} +: 8];
        buf_ridx  = q.cnt[BCNT_W-1:2];
        buf_widx  = q.cnt[BCNT_W-1:2];
        buf_wdata = {in_data, q.acc};
        buf_we    = hs && q.to_buf && (q.cnt[1:0] == 2'd3);

        if (start) begin
            d.active = 1'b1;
            d.to_buf = to_buf;
            d.cnt    = '0;
        end else if (abort) begin
            d.active = 1'b0;
        end else if (hs) begin
            d.cnt = q.cnt + 1'b1;
            if (q.to_buf) begin
                d.acc = {in_data, q.acc[23:8]};
            end
            if (last) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;

    // R1: a new phase starts from byte zero
    a_r1_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.active && q.cnt == '0));

    // R1: the phase ends right after its last byte
    a_r1_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !q.active);

endmodule

// File: rtl/page_dma_mem_eng.sv
module page_dma_mem_eng #(
    parameter int WORDS  = 128,
    parameter int IDX_W  = $clog2(WORDS),
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              to_mem,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic [IDX_W-1:0]  buf_ridx,
    input  logic [31:0]       buf_rdata,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [31:0]       buf_wdata,
    output logic              active,
    output logic              done,
    output logic              err
);

    typedef struct packed {
        logic             active;
        logic             to_mem;
        logic [IDX_W-1:0] idx;
    } mem_st_t;

    mem_st_t q, d;
    logic hs;
    logic last;

    always_comb begin
        d    = q;
        hs   = q.active && mem_ack;
        last = (q.idx == IDX_W'(WORDS - 1));
        err  = hs && mem_err;
        done = hs && !mem_err && last;

        mem_req   = q.active;
        mem_we    = q.active && q.to_mem;
        mem_addr  = base + ADDR_W'({q.idx, 2'b00});
        mem_wdata = buf_rdata;
        buf_ridx  = q.idx;
        buf_widx  = q.idx;
        buf_wdata = mem_rdata;
        buf_we    = hs && !mem_err && !q.to_mem;

        if (start) begin
            d.active = 1'b1;
            d.to_mem = to_mem;
            d.idx    = '0;
        end else if (abort || err) begin
            d.active = 1'b0;
        end else if (hs) begin
            d.idx = q.idx + 1'b1;
            if (last) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;

    // R1: an unacknowledged request holds its word position
    a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !mem_ack && !abort && !start) |=> (q.active && $stable(q.idx)));

    // R7: an errored word ends the phase at once
    a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> !q.active);

endmodule

// File: rtl/page_dma_seq.sv
module page_dma_seq
    import page_dma_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    input  logic              card_in_valid,
    input  logic [7:0]        card_in_data,
    output logic              card_in_ready,
    output logic              card_out_valid,
    output logic [7:0]        card_out_data,
    input  logic              card_out_ready
);

    localparam int WORDS  = PAGE_BYTES / 4;
    localparam int BCNT_W = $clog2(PAGE_BYTES);
    localparam int IDX_W  = $clog2(WORDS);

    typedef struct packed {
        logic              dir;
        logic              int_sel;
        logic              mem_sel;
        logic              stage;
        logic [ADDR_W-1:0] addr;
        logic [EV_N-1:0]   ien;
        logic [EV_N-1:0]   sts;
    } seq_st_t;

    seq_st_t q, d;

    logic             start_card, start_mem, abort;
    logic             card_active, card_done;
    logic             host_active, host_done, host_err;
    logic             busy, cfg_wr, want_int, bad_arm;
    logic [1:0]       phases;

    logic             card_we, host_we;
    logic [IDX_W-1:0] card_ridx, card_widx, host_ridx, host_widx;
    logic [31:0]      card_wdata, host_wdata, card_rdata, host_rdata;
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;
    logic [31:0]      buf_wdata;

    always_comb begin
        d          = q;
        start_card = 1'b0;
        start_mem  = 1'b0;
        abort      = 1'b0;
        busy       = card_active || host_active;
        cfg_wr     = reg_we && (reg_addr == REG_CFG);
        phases     = {reg_wdata[CFG_MEM], reg_wdata[CFG_INT]};
        // first step of a read and second step of a write use the card phase
        want_int   = (!q.stage) == reg_wdata[CFG_DIR];
        bad_arm    = busy || (phases == 2'b11) || (phases[0] != want_int) ||
                     (q.stage && (reg_wdata[CFG_DIR] != q.dir));

        if (reg_we && reg_addr == REG_STS) begin
            d.sts = q.sts & ~reg_wdata[EV_N-1:0];
        end
        if (reg_we && reg_addr == REG_ADDR) begin
            d.addr = ADDR_W'(reg_wdata);
        end
        if (reg_we && reg_addr == REG_IEN) begin
            d.ien = reg_wdata[EV_N-1:0];
        end

        if (card_done) begin
            d.sts[EV_INT] = 1'b1;
            d.int_sel     = 1'b0;
            d.stage       = !q.stage;
        end
        if (host_done) begin
            d.sts[EV_MEM] = 1'b1;
            d.mem_sel     = 1'b0;
            d.stage       = !q.stage;
        end
        if (host_err) begin
            d.sts[EV_ERR] = 1'b1;
            d.int_sel     = 1'b0;
            d.mem_sel     = 1'b0;
            d.stage       = 1'b0;
        end

        if (cfg_wr) begin
            if (phases == 2'b00) begin
                abort     = 1'b1;
                d.dir     = reg_wdata[CFG_DIR];
                d.int_sel = 1'b0;
                d.mem_sel = 1'b0;
                d.stage   = 1'b0;
            end else if (bad_arm) begin
                abort         = 1'b1;
                d.sts[EV_ERR] = 1'b1;
                d.int_sel     = 1'b0;
                d.mem_sel     = 1'b0;
                d.stage       = 1'b0;
            end else begin
                d.dir      = reg_wdata[CFG_DIR];
                d.int_sel  = phases[0];
                d.mem_sel  = phases[1];
                start_card = phases[0];
                start_mem  = phases[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_CFG:  reg_rdata = {29'd0, q.mem_sel, q.int_sel, q.dir};
            REG_ADDR: reg_rdata = 32'(q.addr);
            REG_IEN:  reg_rdata = {{(32-EV_N){1'b0}}, q.ien};
            default:  reg_rdata = {{(32-EV_N){1'b0}}, q.sts};
        endcase
    end

    assign irq = |(q.sts & q.ien);

    assign buf_we    = card_we || host_we;
    assign buf_widx  = card_we ? card_widx  : host_widx;
    assign buf_wdata = card_we ? card_wdata : host_wdata;

    page_dma_buf #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk     (clk),
        .we      (buf_we),
        .widx    (buf_widx),
        .wdata   (buf_wdata),
        .ridx_a  (card_ridx),
        .rdata_a (card_rdata),
        .ridx_b  (host_ridx),
        .rdata_b (host_rdata)
    );

    page_dma_card_eng #(
        .PAGE_BYTES (PAGE_BYTES),
        .BCNT_W     (BCNT_W),
        .IDX_W      (IDX_W)
    ) u_card (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_card),
        .abort     (abort),
        .to_buf    (reg_wdata[CFG_DIR]),
        .in_valid  (card_in_valid),
        .in_data   (card_in_data),
        .in_ready  (card_in_ready),
        .out_valid (card_out_valid),
        .out_data  (card_out_data),
        .out_ready (card_out_ready),
        .buf_ridx  (card_ridx),
        .buf_rdata (card_rdata),
        .buf_we    (card_we),
        .buf_widx  (card_widx),
        .buf_wdata (card_wdata),
        .active    (card_active),
        .done      (card_done)
    );

    page_dma_mem_eng #(
        .WORDS  (WORDS),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_mem),
        .abort     (abort),
        .to_mem    (reg_wdata[CFG_DIR]),
        .base      (q.addr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .buf_ridx  (host_ridx),
        .buf_rdata (host_rdata),
        .buf_we    (host_we),
        .buf_widx  (host_widx),
        .buf_wdata (host_wdata),
        .active    (host_active),
        .done      (host_done),
        .err       (host_err)
    );

    // R4: at most one phase bit is ever set
    a_r4_one_phase_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.mem_sel, q.int_sel}));

    // R4: the two engines never run together
    a_r4_single_engine: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_active && host_active));

    // R8: done events show in status on the next cycle
    a_r8_card_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        card_done |=> q.sts[EV_INT]);
    a_r8_host_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> q.sts[EV_MEM]);

    // R6: arming while busy flags an error and leaves both engines idle
    a_r6_busy_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && phases != 2'b00 && busy) |=> (q.sts[EV_ERR] && !card_active && !host_active));

    // R7: a host error clears the phase bits
    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> (!q.mem_sel && !q.int_sel && q.sts[EV_ERR]));

    // R10: no interrupt while every enable is off
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ien == '0) |-> !irq);

endmodule

// File: tb/page_dma_seq_bench.sv
module page_dma_seq_bench;

    localparam int PAGE = 512;
    localparam int NW   = PAGE / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        mem_err;
    logic        card_in_valid;
    logic [7:0]  card_in_data;
    logic        card_in_ready, card_out_valid;
    logic [7:0]  card_out_data;
    logic        card_out_ready = 1'b1;

    logic        src_en = 1'b0;
    int          src_cnt = 0;
    int          snk_cnt = 0;
    int          mem_cnt = 0;
    int          err_at = -1;
    logic [31:0] wr_mem [1024];
    logic [7:0]  snk [PAGE];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    page_dma_seq u_page_dma_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ack        (mem_ack),
        .mem_err        (mem_err),
        .mem_rdata      (mem_rdata),
        .card_in_valid  (card_in_valid),
        .card_in_data   (card_in_data),
        .card_in_ready  (card_in_ready),
        .card_out_valid (card_out_valid),
        .card_out_data  (card_out_data),
        .card_out_ready (card_out_ready)
    );

    function automatic logic [7:0] src_byte(int n);
        return 8'(n * 37 + 11);
    endfunction

    function automatic logic [31:0] host_pat(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1234_5678;
    endfunction

    // card source, card sink and host memory models
    assign card_in_valid = src_en;
    assign card_in_data  = src_byte(src_cnt);
    assign mem_rdata     = host_pat(mem_addr);
    assign mem_err       = mem_ack && (mem_cnt == err_at);

    always @(posedge clk) begin
        if (card_in_valid && card_in_ready) src_cnt <= src_cnt + 1;
        if (card_out_valid && card_out_ready) begin
            snk[snk_cnt % PAGE] <= card_out_data;
            snk_cnt <= snk_cnt + 1;
        end
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_ack) begin
            mem_cnt <= mem_cnt + 1;
            if (mem_we) wr_mem[mem_addr[11:2]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 32'd0, "R13", "register after reset", v, 32'd0);
        end
        chk({irq, mem_req, card_in_ready, card_out_valid} == 4'd0, "R13", "outputs after reset",
            {28'd0, irq, mem_req, card_in_ready, card_out_valid}, 32'd0);
    endtask

    task automatic t_addr;
        logic [31:0] v;
        wr(2'd1, 32'hDEAD_BEE0);
        rd(2'd1, v);
        chk(v == 32'hDEAD_BEE0, "R11", "address readback", v, 32'hDEAD_BEE0);
    endtask

    task automatic t_read_page;
        logic [31:0] v;
        int s0, m0, miss;
        bit early, quiet;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'h100);
        src_en = 1'b1;
        s0 = src_cnt;
        wr(2'd0, 32'd3);
        rd(2'd0, v);
        chk(v == 32'd3, "R4", "settings while card phase runs", v, 32'd3);
        early = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            if (src_cnt - s0 == PAGE) break;
            if (mem_req) quiet = 1'b0;
            rd(2'd3, v);
            if (v[0]) early = 1'b1;
            @(negedge clk);
        end
        src_en = 1'b0;
        rd(2'd3, v);
        chk(v[0] && !early, "R8", "card done flag timing", v, 32'd1);
        chk(quiet, "R2", "no host request in card phase", 32'(quiet), 32'd1);
        rd(2'd0, v);
        chk(v == 32'd1, "R4", "card phase bit cleared", v, 32'd1);

        m0 = mem_cnt;
        wr(2'd0, 32'd5);
        early = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (mem_cnt - m0 == NW) break;
            rd(2'd3, v);
            if (v[1]) early = 1'b1;
            @(negedge clk);
        end
        rd(2'd3, v);
        chk(v == 32'd3 && !early, "R8", "host done flag timing", v, 32'd3);
        repeat (4) @(negedge clk);
        chk(mem_cnt - m0 == NW && !mem_req, "R1", "host word count",
            32'(mem_cnt - m0), 32'(NW));
        miss = 0;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] e;
            e = {src_byte(s0 + 4*w + 3), src_byte(s0 + 4*w + 2),
                 src_byte(s0 + 4*w + 1), src_byte(s0 + 4*w)};
            if (wr_mem[64 + w] !== e) miss++;
        end
        chk(miss == 0, "R2", "page written to host", 32'(miss), 32'd0);

        chk(!irq, "R10", "irq with enables off", 32'(irq), 32'd0);
        wr(2'd2, 32'd2);
        chk(irq, "R10", "irq on host done enable", 32'(irq), 32'd1);
        wr(2'd2, 32'd4);
        chk(!irq, "R10", "irq with only error enabled", 32'(irq), 32'd0);
        wr(2'd2, 32'd0);

        wr(2'd3, 32'd0);
        rd(2'd3, v);
        chk(v == 32'd3, "R9", "write of zero keeps status", v, 32'd3);
        wr(2'd3, 32'd1);
        rd(2'd3, v);
        chk(v == 32'd2, "R9", "clear card done only", v, 32'd2);
        wr(2'd3, 32'd2);
        rd(2'd3, v);
        chk(v == 32'd0, "R9", "clear host done", v, 32'd0);
    endtask

    task automatic t_write_page;
        logic [31:0] v;
        int m0, k0, miss;
        bit quiet;
        wr(2'd1, 32'h400);
        m0 = mem_cnt;
        wr(2'd0, 32'd4);
        quiet = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            if (mem_cnt - m0 == NW) break;
            if (card_out_valid) quiet = 1'b0;
            @(negedge clk);
        end
        rd(2'd3, v);
        chk(v == 32'd2, "R8", "host phase done in write", v, 32'd2);
        chk(quiet && !mem_we, "R3", "no card output in host phase", 32'(quiet), 32'd1);
        k0 = snk_cnt;
        wr(2'd0, 32'd2);
        for (int i = 0; i < 2000; i++) begin
            if (snk_cnt - k0 == PAGE) break;
            @(negedge clk);
        end
        rd(2'd3, v);
        chk(v == 32'd3, "R3", "both phases done in write", v, 32'd3);
        miss = 0;
        for (int k = 0; k < PAGE; k++) begin
            logic [31:0] word;
            word = host_pat(32'h400 + 32'(4 * (k / 4)));
            if (snk[(k0 + k) % PAGE] !== word[8*(k%4) +: 8]) miss++;
        end
        chk(miss == 0, "R3", "card bytes from host page", 32'(miss), 32'd0);
        wr(2'd3, 32'd7);
    endtask

    task automatic t_order_err;
        logic [31:0] v;
        wr(2'd0, 32'd5);
        rd(2'd3, v);
        chk(v == 32'd4, "R5", "host phase first in read", v, 32'd4);
        chk(!mem_req, "R5", "no request after bad arm", 32'(mem_req), 32'd0);
        rd(2'd0, v);
        chk((v & 32'd6) == 32'd0, "R5", "phase bits after bad arm", v, 32'd0);
        wr(2'd3, 32'd7);
        wr(2'd0, 32'd7);
        rd(2'd3, v);
        chk(v == 32'd4, "R5", "both phase bits", v, 32'd4);
        wr(2'd3, 32'd7);
    endtask

    task automatic t_busy_err;
        logic [31:0] v;
        src_en = 1'b0;
        wr(2'd0, 32'd3);
        chk(card_in_ready, "R6", "card phase running", 32'(card_in_ready), 32'd1);
        wr(2'd0, 32'd3);
        rd(2'd3, v);
        chk(v == 32'd4, "R6", "error on arm while busy", v, 32'd4);
        chk(!card_in_ready && !mem_req, "R6", "running phase stopped",
            32'(card_in_ready), 32'd0);
        rd(2'd0, v);
        chk((v & 32'd6) == 32'd0, "R6", "phase bits after busy arm", v, 32'd0);
        wr(2'd3, 32'd7);
    endtask

    task automatic t_mem_err_cancel;
        logic [31:0] v;
        int s0, m0;
        wr(2'd1, 32'h200);
        src_en = 1'b1;
        s0 = src_cnt;
        wr(2'd0, 32'd3);
        for (int i = 0; i < 2000; i++) begin
            if (src_cnt - s0 == PAGE) break;
            @(negedge clk);
        end
        src_en = 1'b0;
        m0 = mem_cnt;
        err_at = m0 + 5;
        wr(2'd0, 32'd5);
        for (int i = 0; i < 2000; i++) begin
            rd(2'd3, v);
            if (v[2]) break;
            @(negedge clk);
        end
        chk(v == 32'd5, "R7", "error flag on host error", v, 32'd5);
        chk(mem_cnt - m0 == 6 && !mem_req, "R7", "host phase stopped at error",
            32'(mem_cnt - m0), 32'd6);
        rd(2'd0, v);
        chk((v & 32'd6) == 32'd0, "R7", "phase bits after host error", v, 32'd0);
        err_at = -1;
        wr(2'd3, 32'd7);
        wr(2'd0, 32'd5);
        rd(2'd3, v);
        chk(v == 32'd4, "R7", "sequence back at first step", v, 32'd4);
        wr(2'd3, 32'd7);
        wr(2'd0, 32'd3);
        rd(2'd3, v);
        chk(card_in_ready && v == 32'd0, "R12", "card phase armed again", v, 32'd0);
        wr(2'd0, 32'd0);
        rd(2'd3, v);
        chk(!card_in_ready && v == 32'd0, "R12", "cancel without error", v, 32'd0);
        wr(2'd0, 32'd5);
        rd(2'd3, v);
        chk(v == 32'd4, "R12", "cancel returns to first step", v, 32'd4);
        wr(2'd3, 32'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_addr;
        t_read_page;
        t_write_page;
        t_order_err;
        t_busy_err;
        t_mem_err_cancel;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule